// File: doc/BRIEF.md
# Associative Page Table Translator

This block turns a 13-bit virtual address into a 12-bit physical address. The top three bits of the virtual address select a page, and the low ten bits give a line within that page. The page table has one entry per physical block, four in all. Each entry holds a page number, the block that page sits in, and a valid flag. On each request the page number is compared with every valid entry at the same time. A hit replaces the page number with the entry's 2-bit block number. The line offset passes through unchanged.

When no valid entry holds the requested page, the block raises a fault so that software can bring the page in. Software installs mappings through a load port by naming the entry to write. A load is refused, and an error is flagged, if the same page already sits in a different valid entry. This keeps a page in at most one entry, so two entries can never match the same lookup.

Top module: `page_xlate`

## Requirements
- R1: After reset every entry is invalid, and `rsp_valid`, `rsp_fault`, `rsp_paddr` and `ld_dup_err` are all 0. A request made before any load therefore faults.
- R2: `rsp_valid` is high for exactly the cycle after a cycle with `req_valid` high, and low in every other cycle.
- R3: On a hit, `rsp_paddr` holds the matching entry's block in bits [11:10] and the request's line offset in bits [9:0]. `rsp_fault` is 0.
- R4: On a miss (no valid entry holds the page in bits [12:10] of `req_vaddr`), `rsp_fault` is 1 and `rsp_paddr` is {2'b00, line offset}.
- R5: `rsp_fault` and `rsp_paddr` keep their values until the next request is answered.
- R6: A load with `ld_en` high writes the page and block into entry `ld_idx` and marks that entry valid, one cycle later. Overwriting an entry removes its old page mapping.
- R7: A load whose page sits in a valid entry other than `ld_idx` is refused and leaves the table unchanged. `ld_dup_err` is then high for the one following cycle.
- R8: Loading a page into the entry that already holds it is not a duplicate. The load is accepted and replaces the block number.
- R9: A request in the same cycle as a load is translated against the table as it was before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 13 | Virtual address: page [12:10], line [9:0] |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 12 | Physical address: block [11:10], line [9:0] |
| rsp_fault | output | 1 | Page not mapped; held until the next response |
| ld_en | input | 1 | Load strobe for a table entry |
| ld_idx | input | 2 | Entry to write |
| ld_page | input | 3 | Page number to install |
| ld_block | input | 2 | Block number for that page |
| ld_dup_err | output | 1 | Load refused because the page is already in another entry |

## Verification
Two cases are hard to bring about from the ports.

The first is a duplicate refusal that is also an in-place rewrite. For this, the stimulus loads a page at one index, then tries to load it at a second index, then reloads it at the first. Follow-up requests then show which block the page maps to after each load.

The second is the overlap of a load with a request to the page being loaded. The bench drives both in one cycle and expects a miss, then expects a hit on the next request.

A long run of random requests and loads on a narrow page range then keeps refusals, overwrites and overlaps frequent. The reference model is checked on every clock throughout.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int PAGE_W  = 3,
  parameter int LINE_W  = 10,
  parameter int BLOCK_W = 2,
  parameter int ENTRIES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [PAGE_W+LINE_W-1:0]   req_vaddr,
  output logic                       rsp_valid,
  output logic [BLOCK_W+LINE_W-1:0]  rsp_paddr,
  output logic                       rsp_fault,
  input  logic                       ld_en,
  input  logic [$clog2(ENTRIES)-1:0] ld_idx,
  input  logic [PAGE_W-1:0]          ld_page,
  input  logic [BLOCK_W-1:0]         ld_block,
  output logic                       ld_dup_err
);
  localparam int VA_W  = PAGE_W + LINE_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [PAGE_W-1:0]  pg_q  [ENTRIES];
  logic [BLOCK_W-1:0] blk_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] clash_vec;
  logic [BLOCK_W-1:0] hit_blk;

  wire [PAGE_W-1:0] req_page = req_vaddr[VA_W-1:LINE_W];
  wire [LINE_W-1:0] req_line = req_vaddr[LINE_W-1:0];
  wire              hit      = |hit_vec;
  wire              ld_ok    = ld_en && !(|clash_vec);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec[e]   = vld_q[e] && (pg_q[e] == req_page);
    assign clash_vec[e] = vld_q[e] && (pg_q[e] == ld_page) && (IDX_W'(e) != ld_idx);
  end

  always_comb begin
    hit_blk = '0;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (hit_vec[e]) hit_blk = blk_q[e];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        pg_q[e]  <= '0;
        blk_q[e] <= '0;
      end
    end else if (ld_ok) begin
      vld_q[ld_idx] <= 1'b1;
      pg_q[ld_idx]  <= ld_page;
      blk_q[ld_idx] <= ld_block;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_fault  <= 1'b0;
      ld_dup_err <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      ld_dup_err <= ld_en && !ld_ok;
      if (req_valid) begin
        rsp_fault <= !hit;
        rsp_paddr <= {hit ? hit_blk : {BLOCK_W{1'b0}}, req_line};
      end
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_LINE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_paddr[LINE_W-1:0] == $past(req_line)); // R3
  AST_FAULT_ZERO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr[BLOCK_W+LINE_W-1:LINE_W] == '0); // R4
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_fault) && $stable(rsp_paddr)); // R5
  AST_DUP_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_dup_err |-> $past(ld_en)); // R7
  AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_vec) <= 1); // R7
endmodule

// File: tb/page_xlate_tb_top.sv
module page_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [12:0] req_vaddr = '0;
  logic        rsp_valid;
  logic [11:0] rsp_paddr;
  logic        rsp_fault;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_idx = '0;
  logic [2:0]  ld_page = '0;
  logic [1:0]  ld_block = '0;
  logic        ld_dup_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int m_pg [4];
  int m_blk[4];
  bit m_vld[4];
  bit e_valid, e_fault, e_dup;
  int e_paddr;

  always #10 clk = ~clk;

  page_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_page(ld_page), .ld_block(ld_block),
    .ld_dup_err(ld_dup_err)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(e_valid ? tag : "R2", "rsp_valid", int'(rsp_valid), int'(e_valid));
    chk(e_valid ? tag : "R5", "rsp_fault", int'(rsp_fault), int'(e_fault));
    chk(e_valid ? tag : "R5", "rsp_paddr", int'(rsp_paddr), e_paddr);
    chk(e_dup ? "R7" : tag, "ld_dup_err", int'(ld_dup_err), int'(e_dup));
  endtask

  task automatic step(string tag, bit rq, int pg, int line, bit ld, int idx, int lpg, int lblk);
    int  hb;
    bit  clash;
    req_valid = rq;
    req_vaddr = 13'((pg << 10) | line);
    ld_en     = ld;
    ld_idx    = 2'(idx);
    ld_page   = 3'(lpg);
    ld_block  = 2'(lblk);
    e_valid = rq;
    if (rq) begin
      hb = -1;
      for (int e = 0; e < 4; e++)
        if (m_vld[e] && m_pg[e] == pg && hb < 0) hb = m_blk[e];
      e_fault = (hb < 0);
      e_paddr = ((hb < 0 ? 0 : hb) << 10) | line;
    end
    clash = 1'b0;
    for (int e = 0; e < 4; e++)
      if (m_vld[e] && m_pg[e] == lpg && e != idx) clash = 1'b1;
    e_dup = ld && clash;
    if (ld && !clash) begin
      m_vld[idx] = 1'b1;
      m_pg[idx]  = lpg;
      m_blk[idx] = lblk;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    ld_en     = 1'b0;
    compare(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 0, 0, 1'b0, 0, 0, 0);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 4; e++) begin m_vld[e] = 0; m_pg[e] = 0; m_blk[e] = 0; end
    e_valid = 0; e_fault = 0; e_dup = 0; e_paddr = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    step("R1", 1, 5, 321, 0, 0, 0, 0);
    idle("R5");
    idle("R5");
    step("R6", 0, 0, 0, 1, 0, 1, 3);
    step("R6", 0, 0, 0, 1, 1, 2, 0);
    step("R6", 0, 0, 0, 1, 2, 5, 1);
    step("R6", 0, 0, 0, 1, 3, 6, 2);
    step("R3", 1, 1, 1023, 0, 0, 0, 0);
    step("R3", 1, 2, 0, 0, 0, 0, 0);
    step("R3", 1, 5, 512, 0, 0, 0, 0);
    step("R3", 1, 6, 7, 0, 0, 0, 0);
    idle("R5");
    step("R4", 1, 0, 99, 0, 0, 0, 0);
    step("R4", 1, 7, 1000, 0, 0, 0, 0);
    idle("R5");
    idle("R5");
    step("R7", 0, 0, 0, 1, 0, 5, 3);
    step("R7", 1, 5, 11, 0, 0, 0, 0);
    step("R7", 1, 1, 12, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 2, 5, 0);
    step("R8", 1, 5, 13, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 1, 3, 7, 3);
    step("R6", 1, 6, 14, 0, 0, 0, 0);
    step("R6", 1, 7, 15, 0, 0, 0, 0);
    step("R9", 1, 4, 16, 1, 1, 4, 2);
    step("R9", 1, 4, 17, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 1, 1, 4, 1);
    step("R7", 1, 2, 18, 1, 0, 4, 0);
    for (int k = 0; k < 400; k++) begin
      step("R3", 1'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom_range(0, 1023),
           1'($urandom_range(0, 3) == 0), $urandom_range(0, 3), $urandom_range(0, 7),
           $urandom_range(0, 3));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule